// File: doc/BRIEF.md
# Write-Once Boot Remap Controller

This block holds the one-bit remap state of a system and applies it to the low vector address region. After reset the vector window decodes to the boot ROM. Software running from that ROM copies its vector table into internal SRAM and then writes the control register once. From the next cycle on, the same window decodes to the SRAM. The register is a write-once latch. The first valid write sets it whatever the bus carries, and it stays set until the asynchronous bus reset. The register port therefore takes no write data.

There are two bus-facing sides. The first is an AHB-Lite slave port that exposes the control register inside a small register window. The second is a decode path that watches a master's address phase and returns a one-hot target select, both for the address phase and held for the data phase.

Top module: `boot_remap_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, remap_o is 0 and reads of the control register return 0. Asserting rst_ni clears a set remap state at once.
- R2: The first word-sized write (hsize_i = 3'b010) to register offset 0x04 sets remap_o. remap_o rises on the clock edge that ends that write's data phase.
- R3: After the first accepted write, remap_o stays 1 until reset. Any further write to offset 0x04 completes with OKAY and changes nothing.
- R4: A word read of offset 0x04 returns the remap state in bit 0, with bits 31 to 1 reading as 0.
- R5: A byte or halfword access to offset 0x04 gets a two-cycle ERROR response: hready_o=0 with hresp_o=1, then hready_o=1 with hresp_o=1. It changes neither the remap state nor the write lock, so a later word write still takes effect.
- R6: Accesses to any other offset in the window complete with OKAY. Reads there return 0, and writes there leave the remap state unchanged.
- R7: Every OKAY access completes with no wait states. hready_o is low only in the first cycle of an ERROR response.
- R8: For an active vector-side transfer (vec_htrans_i = 2'b10 or 2'b11), aph_sel_o is 3'b001 (ROM) inside the vector window while remap is 0, and 3'b010 (SRAM) inside it while remap is 1. Outside the window it is 3'b100 (default) whatever the remap state. It is 3'b000 for IDLE or BUSY.
- R9: dph_sel_o loads aph_sel_o on each clock edge where vec_hready_i is 1 and holds while vec_hready_i is 0. A remap change during a stalled data phase leaves that phase's target unchanged.
- R10: Transfers with hsel_i low, or with htrans_i IDLE or BUSY, have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low bus reset |
| hsel_i | input | 1 | Slave select for the register window |
| haddr_i | input | REG_AW (8) | Byte offset within the register window |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | Write when 1 |
| hsize_i | input | 3 | Transfer size |
| hready_i | input | 1 | Bus-level ready (previous transfer done) |
| hrdata_o | output | 32 | Read data |
| hready_o | output | 1 | Slave ready |
| hresp_o | output | 1 | 1 = ERROR response |
| remap_o | output | 1 | Sticky remap state |
| vec_addr_i | input | ADDR_W (32) | Master address being decoded |
| vec_htrans_i | input | 2 | Master transfer type |
| vec_hready_i | input | 1 | Master-side ready, advances the data phase |
| aph_sel_o | output | 3 | Address-phase target select {default, SRAM, ROM} |
| dph_sel_o | output | 3 | Data-phase target select, same encoding |

## Verification
Assertions check the following on every cycle:
- The remap flag never falls without reset, and an accepted write is always followed by a set flag.
- An ERROR response always runs its two-cycle shape, the remap state stays unchanged across it, and hready_o drops only inside that shape.
- The address-phase select is never more than one-hot and never picks SRAM without remap.
- The data-phase select holds steady while the master stalls.

The directed scenarios show what no single-cycle property can:
- Only the first write counts, and a size-error write does not consume that first write.
- Other offsets and deselected cycles leave the state alone.
- The exact cycle in which the window changes target.
- A stalled transfer keeping its ROM target across the change.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [2:0] SIZE_WORD = 3'b010;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned SEL_ROM  = 0;
  localparam int unsigned SEL_SRAM = 1;
  localparam int unsigned SEL_DFLT = 2;

  typedef enum logic [1:0] {
    RSP_OKAY = 2'b00,
    RSP_ERR1 = 2'b01,
    RSP_ERR2 = 2'b10
  } rsp_st_e;

  function automatic logic trans_active(input logic [1:0] t);
    return (t == 2'b10) || (t == 2'b11);
  endfunction
endpackage

// File: rtl/remap_ahb_port.sv
module remap_ahb_port
  import remap_pkg::*;
#(
  parameter int unsigned REG_AW = 8,
  parameter logic [REG_AW-1:0] REG_OFF = 'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [REG_AW-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic              hready_i,
  input  logic              remap_i,
  output logic [DATA_W-1:0] hrdata_o,
  output logic              hready_o,
  output logic              hresp_o,
  output logic              wr_req_o
);
  logic    aph_valid, aph_hit, aph_bad, aph_good;
  logic    dph_wr_q, dph_rd_q;
  rsp_st_e st_q, st_d;

  assign aph_valid = hsel_i && hready_i && trans_active(htrans_i);
  assign aph_hit   = (haddr_i == REG_OFF);
  assign aph_bad   = aph_hit && (hsize_i != SIZE_WORD);
  assign aph_good  = aph_hit && !aph_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dph_wr_q <= 1'b0;
      dph_rd_q <= 1'b0;
    end else if (aph_valid) begin
      dph_wr_q <= aph_good && hwrite_i;
      dph_rd_q <= aph_good && !hwrite_i;
    end else if (hready_i) begin
      dph_wr_q <= 1'b0;
      dph_rd_q <= 1'b0;
    end
  end

  always_comb begin
    st_d = RSP_OKAY;
    unique case (st_q)
      RSP_ERR1: st_d = RSP_ERR2;
      default:  st_d = (aph_valid && aph_bad) ? RSP_ERR1 : RSP_OKAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RSP_OKAY;
    else         st_q <= st_d;
  end

  assign hready_o = (st_q != RSP_ERR1);
  assign hresp_o  = (st_q != RSP_OKAY);
  assign hrdata_o = dph_rd_q ? {{(DATA_W-1){1'b0}}, remap_i} : '0;
  assign wr_req_o = dph_wr_q;

  // R5
  err_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && !hready_o) |=> (hresp_o && hready_o));
  // R7
  zero_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_o |-> hresp_o);
  // R5
  err_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hresp_o) |-> !hready_o);
endmodule

// File: rtl/remap_state.sv
module remap_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  output logic remap_o
);
  logic lock_q, remap_q;

  // lock gates every write after the first; data is never looked at
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      remap_q <= 1'b0;
    end else if (wr_req_i && !lock_q) begin
      lock_q  <= 1'b1;
      remap_q <= 1'b1;
    end
  end

  assign remap_o = remap_q;

  // R3
  remap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_q |=> remap_q);
  // R2
  remap_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> remap_q);
endmodule

// File: rtl/remap_vec_decode.sv
module remap_vec_decode
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int unsigned VEC_LOG2 = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              remap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hready_i,
  output logic [SEL_W-1:0]  aph_sel_o,
  output logic [SEL_W-1:0]  dph_sel_o
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << VEC_LOG2) - 64'd1);
  localparam logic [ADDR_W-1:0] TAG      = VEC_BASE & ~OFS_MASK;

  logic             in_win;
  logic [SEL_W-1:0] dph_q;

  assign in_win = ((addr_i & ~OFS_MASK) == TAG);

  always_comb begin
    aph_sel_o = '0;
    if (trans_active(htrans_i)) begin
      if (!in_win)      aph_sel_o[SEL_DFLT] = 1'b1;
      else if (remap_i) aph_sel_o[SEL_SRAM] = 1'b1;
      else              aph_sel_o[SEL_ROM]  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dph_q <= '0;
    else if (hready_i) dph_q <= aph_sel_o;
  end

  assign dph_sel_o = dph_q;

  // R8
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(aph_sel_o));
  // R8
  sram_needs_remap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aph_sel_o[SEL_SRAM] |-> remap_i);
  // R9
  dph_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> $stable(dph_sel_o));
endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
  import remap_pkg::*;
#(
  parameter int unsigned REG_AW   = 8,
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int unsigned VEC_LOG2 = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [REG_AW-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic              hready_i,
  output logic [31:0]       hrdata_o,
  output logic              hready_o,
  output logic              hresp_o,
  output logic              remap_o,
  input  logic [ADDR_W-1:0] vec_addr_i,
  input  logic [1:0]        vec_htrans_i,
  input  logic              vec_hready_i,
  output logic [2:0]        aph_sel_o,
  output logic [2:0]        dph_sel_o
);
  logic wr_req;

  remap_ahb_port #(.REG_AW(REG_AW), .REG_OFF(REG_AW'(4))) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hsel_i   (hsel_i),
    .haddr_i  (haddr_i),
    .htrans_i (htrans_i),
    .hwrite_i (hwrite_i),
    .hsize_i  (hsize_i),
    .hready_i (hready_i),
    .remap_i  (remap_o),
    .hrdata_o (hrdata_o),
    .hready_o (hready_o),
    .hresp_o  (hresp_o),
    .wr_req_o (wr_req)
  );

  remap_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (wr_req),
    .remap_o  (remap_o)
  );

  remap_vec_decode #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_LOG2(VEC_LOG2)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .remap_i   (remap_o),
    .addr_i    (vec_addr_i),
    .htrans_i  (vec_htrans_i),
    .hready_i  (vec_hready_i),
    .aph_sel_o (aph_sel_o),
    .dph_sel_o (dph_sel_o)
  );

  // R5
  err_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hresp_o |=> $stable(remap_o));
endmodule

// File: tb/tb_boot_remap_ctrl.sv
module tb_boot_remap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [7:0]  haddr = '0;
  logic [1:0]  htrans = '0;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'b010;
  logic        hready;
  logic [31:0] hrdata;
  logic        hresp;
  logic        remap;
  logic [31:0] vaddr = '0;
  logic [1:0]  vtrans = '0;
  logic        vready = 1'b1;
  logic [2:0]  aph_sel, dph_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  boot_remap_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel), .haddr_i(haddr), .htrans_i(htrans),
    .hwrite_i(hwrite), .hsize_i(hsize), .hready_i(hready), .hrdata_o(hrdata),
    .hready_o(hready), .hresp_o(hresp), .remap_o(remap), .vec_addr_i(vaddr),
    .vec_htrans_i(vtrans), .vec_hready_i(vready), .aph_sel_o(aph_sel), .dph_sel_o(dph_sel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one transfer; returns at the negedge of the final data-phase cycle
  task automatic bus(input logic sel, input logic [7:0] a, input logic w, input logic [2:0] sz,
                     output logic [31:0] rd, output logic first_err, output logic last_err,
                     output int waits);
    @(negedge clk);
    hsel = sel; haddr = a; htrans = 2'b10; hwrite = w; hsize = sz;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00;
    first_err = hresp;
    waits = 0;
    while (!hready && waits < 8) begin
      waits++;
      @(negedge clk);
    end
    last_err = hresp;
    rd = hrdata;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic e1, e2; int w;
    check(remap == 1'b0, "R1 remap after reset", 32'(remap), 0);
    check(hready && !hresp, "R7 idle response", {30'b0, hready, hresp}, 32'h2);
    check(dph_sel == 3'b000, "R1 dph_sel after reset", 32'(dph_sel), 0);
    bus(1'b1, 8'h04, 1'b0, 3'b010, rd, e1, e2, w);
    check(rd == 32'h0, "R1 readback after reset", rd, 0);
    check(!e2 && w == 0, "R7 read OKAY zero wait", 32'(w), 0);
  endtask

  task automatic t_other_offsets();
    logic [31:0] rd; logic e1, e2; int w;
    bus(1'b1, 8'h00, 1'b1, 3'b010, rd, e1, e2, w);
    check(!e2 && w == 0, "R6 write 0x00 OKAY", 32'(w), 0);
    bus(1'b1, 8'h08, 1'b1, 3'b010, rd, e1, e2, w);
    bus(1'b1, 8'h0C, 1'b1, 3'b000, rd, e1, e2, w);
    check(!e2 && w == 0, "R6 byte write 0x0C OKAY", {31'b0, e2}, 0);
    @(negedge clk);
    check(remap == 1'b0, "R6 other offsets keep remap", 32'(remap), 0);
    bus(1'b1, 8'h08, 1'b0, 3'b010, rd, e1, e2, w);
    check(rd == 32'h0 && !e2, "R6 read 0x08 zero", rd, 0);
    // R10: deselected write, then IDLE/BUSY with select
    bus(1'b0, 8'h04, 1'b1, 3'b010, rd, e1, e2, w);
    @(negedge clk);
    hsel = 1'b1; haddr = 8'h04; hwrite = 1'b1; htrans = 2'b01;
    @(negedge clk);
    htrans = 2'b00;
    @(negedge clk);
    hsel = 1'b0;
    @(negedge clk);
    check(remap == 1'b0, "R10 unselected or idle no effect", 32'(remap), 0);
  endtask

  task automatic t_bad_size();
    logic [31:0] rd; logic e1, e2; int w;
    bus(1'b1, 8'h04, 1'b1, 3'b000, rd, e1, e2, w);
    check(e1 && e2 && w == 1, "R5 byte write error shape", {e1, e2, 30'(w)}, {2'b11, 30'd1});
    bus(1'b1, 8'h04, 1'b1, 3'b001, rd, e1, e2, w);
    check(e1 && e2 && w == 1, "R5 halfword write error shape", {e1, e2, 30'(w)}, {2'b11, 30'd1});
    @(negedge clk);
    check(remap == 1'b0, "R5 error keeps remap clear", 32'(remap), 0);
    check(hready && !hresp, "R5 response back to OKAY", {30'b0, hready, hresp}, 32'h2);
  endtask

  task automatic t_decode_rom();
    @(negedge clk);
    vaddr = 32'h0000_1234; vtrans = 2'b10;
    #1 check(aph_sel == 3'b001, "R8 window to ROM", 32'(aph_sel), 1);
    vaddr = 32'h0001_0000;
    #1 check(aph_sel == 3'b100, "R8 outside window default", 32'(aph_sel), 4);
    vaddr = 32'h0000_FFFC; vtrans = 2'b11;
    #1 check(aph_sel == 3'b001, "R8 window top SEQ to ROM", 32'(aph_sel), 1);
    vtrans = 2'b00;
    #1 check(aph_sel == 3'b000, "R8 idle no select", 32'(aph_sel), 0);
  endtask

  task automatic t_first_write();
    logic [31:0] rd; logic e1, e2; int w;
    @(negedge clk);
    vaddr = 32'h0000_0100; vtrans = 2'b10; vready = 1'b1;
    @(negedge clk);
    check(dph_sel == 3'b001, "R9 data phase to ROM", 32'(dph_sel), 1);
    vready = 1'b0;
    bus(1'b1, 8'h04, 1'b1, 3'b010, rd, e1, e2, w);
    check(remap == 1'b0 && !e2 && w == 0, "R2 remap low during data phase", 32'(remap), 0);
    @(negedge clk);
    check(remap == 1'b1, "R2 first write sets remap", 32'(remap), 1);
    check(aph_sel == 3'b010, "R8 window to SRAM", 32'(aph_sel), 2);
    check(dph_sel == 3'b001, "R9 stalled phase keeps ROM", 32'(dph_sel), 1);
    vready = 1'b1;
    @(negedge clk);
    check(dph_sel == 3'b010, "R9 next phase to SRAM", 32'(dph_sel), 2);
    vaddr = 32'h2000_0000;
    #1 check(aph_sel == 3'b100, "R8 outside default with remap", 32'(aph_sel), 4);
    vtrans = 2'b00;
  endtask

  task automatic t_later_writes();
    logic [31:0] rd; logic e1, e2; int w;
    bus(1'b1, 8'h04, 1'b1, 3'b010, rd, e1, e2, w);
    check(!e2 && w == 0, "R3 second write OKAY", {31'b0, e2}, 0);
    @(negedge clk);
    check(remap == 1'b1, "R3 remap stays set", 32'(remap), 1);
    bus(1'b1, 8'h04, 1'b0, 3'b010, rd, e1, e2, w);
    check(rd == 32'h1, "R4 readback bit0 only", rd, 1);
    bus(1'b1, 8'h04, 1'b1, 3'b001, rd, e1, e2, w);
    check(e1 && e2 && w == 1, "R5 halfword error after lock", {e1, e2, 30'(w)}, {2'b11, 30'd1});
    bus(1'b1, 8'h04, 1'b0, 3'b010, rd, e1, e2, w);
    check(rd == 32'h1, "R3 remap after error", rd, 1);
  endtask

  task automatic t_reset_clear();
    logic [31:0] rd; logic e1, e2; int w;
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1 check(remap == 1'b0, "R1 async reset clears remap", 32'(remap), 0);
    @(negedge clk);
    rst_n = 1'b1;
    bus(1'b1, 8'h04, 1'b0, 3'b010, rd, e1, e2, w);
    check(rd == 32'h0, "R1 readback cleared", rd, 0);
    bus(1'b1, 8'h04, 1'b1, 3'b010, rd, e1, e2, w);
    @(negedge clk);
    check(remap == 1'b1, "R2 write after reset sets again", 32'(remap), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_other_offsets();
    t_bad_size();
    t_decode_rom();
    t_first_write();
    t_later_writes();
    t_reset_clear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule